// File: doc/BRIEF.md
# Dual-Format Precision Time Counter

This block is a free-running hardware time-of-day counter for precision time protocol work. On every rising clock edge it advances a time value by a configured clock period, given as whole nanoseconds plus a 16-bit binary fraction of a nanosecond. It presents the time in two packed formats at once. The first is a wide seconds / nanoseconds / fraction word. The second is a compact total-nanoseconds / fraction word. It also raises a one-cycle pulse whenever the seconds count advances.

A clock period that cannot be written exactly in 1/65536 ns units would slowly drift. To stop this, the block has a periodic correction. A down-counter, loaded with the correction interval minus one, expires once per interval. On the cycle it expires, an extra fractional amount is added on top of the normal step. Over many cycles this cancels the rounding error of the period. The nanoseconds-to-seconds rollover uses compare and subtract, so no divider is needed.

Top module: `ptp_ts_counter`

## Requirements
- R1: The wide output `ts96` holds seconds in bits [95:48], nanoseconds in bits [47:16] and fractional nanoseconds (units of 1/65536 ns) in bits [15:0].
- R2: The compact output `ts64` holds total elapsed nanoseconds in bits [63:16] and fractional nanoseconds in bits [15:0]. Seconds times 1,000,000,000 plus nanoseconds in `ts96` always equals the total in `ts64`.
- R3: Each cycle out of reset adds `periodNs` nanoseconds and `periodFns` fractional nanoseconds to the time. A carry out of the 16-bit fraction adds to the nanoseconds.
- R4: The nanoseconds field of `ts96` stays below 1,000,000,000. When a step reaches or passes that value, the value is subtracted and seconds increase by one. An exact landing on the boundary gives nanoseconds 0.
- R5: The fractional field is identical in `ts96` and `ts64`.
- R6: `pps` is high for exactly the cycles in which the seconds field of `ts96` differs from its value on the previous cycle.
- R7: A synchronous active-high `rst` clears `ts96`, `ts64`, `pps` and the correction counter to zero on the next edge.
- R8: With `driftRate` = 0, no correction is applied. With `driftRate` = N > 0, `driftFns` is added to the fractional sum on the first cycle after reset and then once every N cycles. The counter reloads with N−1 each time it expires.
- R9: With a period of 6 ns + 0x6666, `driftRate` = 5 and `driftFns` = 2, `ts64` reads exactly 64,000 ns with a zero fraction after 10,000 cycles from reset.
- R10: Outside reset, `ts64` never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; time advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| periodNs | input | 20 | Whole nanoseconds added per cycle |
| periodFns | input | 16 | Fractional nanoseconds added per cycle |
| driftRate | input | 16 | Correction interval in cycles; 0 disables correction |
| driftFns | input | 16 | Extra fractional nanoseconds added when the correction counter expires |
| ts96 | output | 96 | Seconds / nanoseconds / fraction time |
| ts64 | output | 64 | Total nanoseconds / fraction time |
| pps | output | 1 | One-cycle pulse on each seconds change |

## Verification
Some properties are checked by the assertions on every cycle: agreement between the two formats, the nanoseconds field staying below one billion, seconds advancing by at most one, the pulse matching each seconds change exactly, monotonic total time, and zeroed outputs after reset. The exact amount added per step, the timing of the drift correction within its interval, landing exactly on a seconds boundary, and the long-run accuracy of a non-representable period can only be shown by the bench's directed scenarios. The bench compares against its own cycle-by-cycle time model in those scenarios.

// File: rtl/ptp_ts_pkg.sv
`timescale 1ns / 1ps
package ptp_ts_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic clear;       // synchronous clear of all time state
    logic driftApply;  // add the correction fraction this cycle
  } tsCtrl_t;
endpackage

// File: rtl/ptp_ts_ctrl.sv
`timescale 1ns / 1ps
module ptp_ts_ctrl
  import ptp_ts_pkg::*;
#(
  parameter int DRIFT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DRIFT_W-1:0] driftRate,
  input  logic               secWrap,
  output tsCtrl_t            ctrl,
  output logic               pps
);
  logic [DRIFT_W-1:0] driftCnt;
  logic               driftHit;

  // Correction fires when the counter has run out and correction is enabled
  always_comb begin
    driftHit        = (driftCnt == '0) && (driftRate != '0);
    ctrl.clear      = rst;
    ctrl.driftApply = driftHit && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      driftCnt <= '0;
      pps      <= 1'b0;
    end else begin
      if (driftCnt != '0) begin
        driftCnt <= driftCnt - 1'b1;
      end else if (driftRate != '0) begin
        driftCnt <= driftRate - 1'b1;
      end
      // Pulse is registered alongside the seconds update it reports
      pps <= secWrap;
    end
  end
endmodule

// File: rtl/ptp_ts_datapath.sv
`timescale 1ns / 1ps
module ptp_ts_datapath
  import ptp_ts_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FNS_W      = 16,
  parameter int TOT_W      = 48,
  parameter int PER_NS_W   = 20,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                clk,
  input  tsCtrl_t             ctrl,
  input  logic [PER_NS_W-1:0] periodNs,
  input  logic [FNS_W-1:0]    periodFns,
  input  logic [FNS_W-1:0]    driftFns,
  output logic [SEC_W-1:0]    secQ,
  output logic [NS_W-1:0]     nsQ,
  output logic [FNS_W-1:0]    fnsQ,
  output logic [TOT_W-1:0]    totQ,
  output logic                secWrap
);
  localparam int SUM_W = FNS_W + 2;
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_PER_SEC);

  logic [SUM_W-1:0] driftAdd;
  logic [SUM_W-1:0] fracSum;
  logic [NS_W-1:0]  nsStep;
  logic [NS_W-1:0]  nsSum;
  logic [NS_W-1:0]  nsNext;

  always_comb begin
    driftAdd = ctrl.driftApply ? SUM_W'(driftFns) : '0;
    fracSum  = SUM_W'(fnsQ) + SUM_W'(periodFns) + driftAdd;
    // Whole nanoseconds of this step, including up to two fraction carries
    nsStep   = NS_W'(periodNs) + NS_W'(fracSum[SUM_W-1:FNS_W]);
    nsSum    = nsQ + nsStep;
    secWrap  = (nsSum >= NS_LIMIT);
    nsNext   = secWrap ? (nsSum - NS_LIMIT) : nsSum;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      secQ <= '0;
      nsQ  <= '0;
      fnsQ <= '0;
      totQ <= '0;
    end else begin
      fnsQ <= fracSum[FNS_W-1:0];
      nsQ  <= nsNext;
      totQ <= totQ + TOT_W'(nsStep);
      if (secWrap) begin
        secQ <= secQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptp_ts_counter.sv
`timescale 1ns / 1ps
module ptp_ts_counter
  import ptp_ts_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FNS_W      = 16,
  parameter int TOT_W      = 48,
  parameter int PER_NS_W   = 20,
  parameter int DRIFT_W    = 16,
  parameter int NS_PER_SEC = 1000000000,
  localparam int TS96_W    = SEC_W + NS_W + FNS_W,
  localparam int TS64_W    = TOT_W + FNS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PER_NS_W-1:0] periodNs,
  input  logic [FNS_W-1:0]    periodFns,
  input  logic [DRIFT_W-1:0]  driftRate,
  input  logic [FNS_W-1:0]    driftFns,
  output logic [TS96_W-1:0]   ts96,
  output logic [TS64_W-1:0]   ts64,
  output logic                pps
);
  tsCtrl_t           ctrl;
  logic              secWrap;
  logic [SEC_W-1:0]  secQ;
  logic [NS_W-1:0]   nsQ;
  logic [FNS_W-1:0]  fnsQ;
  logic [TOT_W-1:0]  totQ;

  ptp_ts_ctrl #(
    .DRIFT_W(DRIFT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .driftRate(driftRate),
    .secWrap  (secWrap),
    .ctrl     (ctrl),
    .pps      (pps)
  );

  ptp_ts_datapath #(
    .SEC_W     (SEC_W),
    .NS_W      (NS_W),
    .FNS_W     (FNS_W),
    .TOT_W     (TOT_W),
    .PER_NS_W  (PER_NS_W),
    .NS_PER_SEC(NS_PER_SEC)
  ) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .periodNs (periodNs),
    .periodFns(periodFns),
    .driftFns (driftFns),
    .secQ     (secQ),
    .nsQ      (nsQ),
    .fnsQ     (fnsQ),
    .totQ     (totQ),
    .secWrap  (secWrap)
  );

  assign ts96 = {secQ, nsQ, fnsQ};
  assign ts64 = {totQ, fnsQ};
endmodule

// File: rtl/ptp_ts_counter_chk.sv
`timescale 1ns / 1ps
module ptp_ts_counter_chk #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FNS_W      = 16,
  parameter int TOT_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  localparam int TS96_W    = SEC_W + NS_W + FNS_W,
  localparam int TS64_W    = TOT_W + FNS_W
) (
  input logic              clk,
  input logic              rst,
  input logic [TS96_W-1:0] ts96,
  input logic [TS64_W-1:0] ts64,
  input logic              pps
);
  logic [SEC_W-1:0] sec;
  logic [NS_W-1:0]  ns;
  logic [TOT_W-1:0] tot;
  logic [127:0]     recon;

  assign sec   = ts96[TS96_W-1 -: SEC_W];
  assign ns    = ts96[FNS_W +: NS_W];
  assign tot   = ts64[TS64_W-1 -: TOT_W];
  assign recon = 128'(sec) * 128'(NS_PER_SEC) + 128'(ns);

  AST_FMT_AGREE: assert property (@(posedge clk) disable iff (rst)
    recon == 128'(tot)); // R2

  AST_NS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    128'(ns) < 128'(NS_PER_SEC)); // R4

  AST_SEC_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (sec != $past(sec)) |-> (sec == $past(sec) + 1'b1)); // R4

  AST_PPS_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (sec != $past(sec)) |-> pps); // R6

  AST_PPS_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
    pps |-> (sec != $past(sec))); // R6

  AST_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    ts64 >= $past(ts64)); // R10

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (ts96 == '0 && ts64 == '0 && !pps)); // R7
endmodule

bind ptp_ts_counter ptp_ts_counter_chk #(
  .SEC_W     (SEC_W),
  .NS_W      (NS_W),
  .FNS_W     (FNS_W),
  .TOT_W     (TOT_W),
  .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk (clk),
  .rst (rst),
  .ts96(ts96),
  .ts64(ts64),
  .pps (pps)
);

// File: tb/ptp_ts_counter_bench.sv
`timescale 1ns / 1ps
module ptp_ts_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] periodNs = '0;
  logic [15:0] periodFns = '0;
  logic [15:0] driftRate = '0;
  logic [15:0] driftFns = '0;
  logic [95:0] ts96;
  logic [63:0] ts64;
  logic        pps;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Bench time model
  longint mTot, mFns, mCnt, mSec;
  bit     mPps;
  logic [63:0] lastTs64;

  always #2.5 clk = ~clk;

  ptp_ts_counter u_ptp_ts_counter (
    .clk(clk), .rst(rst), .periodNs(periodNs), .periodFns(periodFns),
    .driftRate(driftRate), .driftFns(driftFns),
    .ts96(ts96), .ts64(ts64), .pps(pps)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] exp96();
    return {48'(mTot / 64'd1000000000), 32'(mTot % 64'd1000000000), 16'(mFns)};
  endfunction

  function automatic logic [63:0] exp64();
    return {48'(mTot), 16'(mFns)};
  endfunction

  task automatic modelClear();
    mTot = 0; mFns = 0; mCnt = 0; mSec = 0; mPps = 0;
    lastTs64 = '0;
  endtask

  task automatic modelStep();
    bit hit;
    longint s, nsec;
    hit = (mCnt == 0) && (driftRate != 0);
    if (mCnt != 0) mCnt = mCnt - 1;
    else if (driftRate != 0) mCnt = longint'(driftRate) - 1;
    s = mFns + longint'(periodFns) + (hit ? longint'(driftFns) : 0);
    mFns = s % 65536;
    mTot = mTot + longint'(periodNs) + s / 65536;
    nsec = mTot / 64'd1000000000;
    mPps = (nsec != mSec);
    mSec = nsec;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelClear();
  endtask

  // Advance n cycles, comparing every cycle against the model
  task automatic runLockstep(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      modelStep();
      check(ts96 == exp96(), {tag, " R1 R4 ts96"}, 128'(ts96), 128'(exp96()));
      check(ts64 == exp64(), {tag, " R2 R3 ts64"}, 128'(ts64), 128'(exp64()));
      check(ts96[15:0] == ts64[15:0], {tag, " R5 fraction"}, 128'(ts96[15:0]), 128'(ts64[15:0]));
      check(pps == mPps, {tag, " R6 pps"}, 128'(pps), 128'(mPps));
      check(ts64 >= lastTs64, {tag, " R10 monotonic"}, 128'(ts64), 128'(lastTs64));
      lastTs64 = ts64;
    end
  endtask

  task automatic testReset();
    periodNs = 20'd7; periodFns = 16'h1234; driftRate = 16'd2; driftFns = 16'h10;
    doReset();
    check(ts96 == '0 && ts64 == '0 && !pps, "R7 after reset", {ts96, ts64[31:0]}, '0);
    runLockstep(10, "reset-run");
    doReset();
    check(ts96 == '0 && ts64 == '0 && !pps, "R7 mid-run reset", {ts96, ts64[31:0]}, '0);
  endtask

  task automatic testBasic();
    periodNs = 20'd5; periodFns = 16'h8000; driftRate = '0; driftFns = 16'hFFFF;
    doReset();
    runLockstep(20, "basic");
    // 20 cycles of 5.5 ns = 110 ns, fraction 0; drift ignored with rate 0
    check(ts64 == {48'd110, 16'h0}, "R8 R3 rate zero ignores drift", 128'(ts64), 128'({48'd110, 16'h0}));
  endtask

  task automatic testDrift();
    periodNs = 20'd1; periodFns = 16'h1000; driftRate = 16'd3; driftFns = 16'h4000;
    doReset();
    runLockstep(3, "drift");
    // hit on cycle 1 only: fraction 3*0x1000 + 0x4000 = 0x7000
    check(ts64 == {48'd3, 16'h7000}, "R8 first-cycle correction", 128'(ts64), 128'({48'd3, 16'h7000}));
    runLockstep(30, "drift-interval");
    driftRate = 16'd1; driftFns = 16'hF000;
    doReset();
    runLockstep(25, "drift-every-cycle");
  endtask

  task automatic testWrapExact();
    periodNs = 20'd250000; periodFns = '0; driftRate = '0; driftFns = '0;
    doReset();
    runLockstep(3999, "wrap-approach");
    check(!pps && ts96[95:48] == 48'd0, "R6 no pulse before wrap", 128'(pps), 128'(0));
    runLockstep(1, "wrap-exact");
    check(ts96 == {48'd1, 32'd0, 16'd0}, "R4 exact boundary", 128'(ts96), 128'({48'd1, 32'd0, 16'd0}));
    check(pps == 1'b1, "R6 pulse at wrap", 128'(pps), 128'(1));
    runLockstep(1, "wrap-after");
    check(pps == 1'b0, "R6 one-cycle pulse", 128'(pps), 128'(0));
  endtask

  task automatic testWrapMany();
    periodNs = 20'd333333; periodFns = 16'hAAAA; driftRate = 16'd7; driftFns = 16'h0123;
    doReset();
    runLockstep(3000, "wrap-many");
  endtask

  task automatic testAccuracy();
    periodNs = 20'd6; periodFns = 16'h6666; driftRate = 16'd5; driftFns = 16'd2;
    doReset();
    runLockstep(10000, "accuracy");
    check(ts64 == {48'd64000, 16'h0}, "R9 10000-cycle accuracy", 128'(ts64), 128'({48'd64000, 16'h0}));
  endtask

  initial begin
    modelClear();
    testReset();
    testBasic();
    testDrift();
    testWrapExact();
    testWrapMany();
    testAccuracy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule